// File: doc/BRIEF.md
# Keypad Code Lock Controller

This controller watches a stream of decimal key presses and opens a lock only when the fixed three-digit code 1, 4, 2 arrives in that order. Each press shows up as a 4-bit key value with a one-cycle valid strobe. The controller records each correctly matched digit in its own state. One wrong digit sends it to an alarm state. That state persists until a clear pulse arrives.

The current state is decoded into an unlock output and an alarm output. The raw state code is also brought out, so the position in the sequence can be read directly from the flip-flops. All state changes happen on the rising clock edge. The active-low asynchronous reset is meant only for power-up and forces the idle state. Keypad scanning, debouncing and timeouts are handled elsewhere.

Top module: `keypad_lock`

## Requirements
- R1: While rst_ni is low, and at the first edge after it is released, the state is idle (code 000) with unlock_o and alarm_o low. Asserting rst_ni in the middle of a run forces idle at once, without waiting for a clock edge.
- R2: state_o carries unique codes: idle 000, one digit matched 001, two matched 010, three matched 011, open 100, alarm 101. No other code ever appears, and unlock_o and alarm_o are never both high.
- R3: A valid key equal to the next expected digit (1 from idle, 4 after one match, 2 after two matches) advances the state by one on that clock edge.
- R4: In any state other than three-matched, a cycle with key_valid_i low leaves the state unchanged. The only exception is a clear in alarm (see R8).
- R5: The three-matched state moves to open on the next clock edge whatever the inputs are. unlock_o is high only in the open state.
- R6: From open, the next valid key of any value, including 1, returns the state to idle.
- R7: A valid key that differs from the expected digit in idle, one-matched or two-matched moves the state to alarm. This includes key values 10 to 15. alarm_o is high only in alarm.
- R8: Alarm ignores all key presses. It leaves only when clear_i is high at a clock edge, and then goes to idle. Clear wins over a simultaneous key.
- R9: clear_i has no effect in any state other than alarm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| key_i | input | 4 | Key value of the current press |
| key_valid_i | input | 1 | One-cycle strobe qualifying key_i |
| clear_i | input | 1 | Releases the alarm state |
| unlock_o | output | 1 | High while in the open state |
| alarm_o | output | 1 | High while in the alarm state |
| state_o | output | 3 | Current state code |

## Verification
The bench covers wrong digits at each of the three match positions. A design that only checked the first digit, or that restarted matching instead of alarming, would fail to reach alarm there. Pressing 1 while open must land in idle, not one-matched. A design that re-evaluated the code from open would show 001. Keys sent in the three-matched state must not stop the move to open. A clear outside alarm must not reset progress. In alarm, a clear that arrives with a key must win, and a design that let the key through would stay in alarm. Out-of-range key values and a mid-run asynchronous reset are also covered.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int STATE_W  = 3;
  localparam int CODE_LEN = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'b000,
    ST_HIT1  = 3'b001,
    ST_HIT2  = 3'b010,
    ST_HIT3  = 3'b011,
    ST_OPEN  = 3'b100,
    ST_ALARM = 3'b101
  } lock_state_e;
endpackage

// File: rtl/lock_digit_match.sv
module lock_digit_match #(
  parameter int DIGIT_W  = 4,
  parameter int CODE_LEN = 3,
  parameter logic [CODE_LEN*DIGIT_W-1:0] CODE = '0
) (
  input  logic [DIGIT_W-1:0]  key_i,
  output logic [CODE_LEN-1:0] hit_o
);
  for (genvar i = 0; i < CODE_LEN; i++) begin : g_cmp
    assign hit_o[i] = (key_i == CODE[i*DIGIT_W +: DIGIT_W]);
  end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
  import lock_pkg::*;
#(
  parameter int CODE_LEN = 3
) (
  input  lock_state_e         state_i,
  input  logic                key_valid_i,
  input  logic                clear_i,
  input  logic [CODE_LEN-1:0] hit_i,
  output lock_state_e         next_o
);
  always_comb begin
    next_o = state_i;
    unique case (state_i)
      ST_IDLE:  if (key_valid_i) next_o = hit_i[0] ? ST_HIT1 : ST_ALARM;
      ST_HIT1:  if (key_valid_i) next_o = hit_i[1] ? ST_HIT2 : ST_ALARM;
      ST_HIT2:  if (key_valid_i) next_o = hit_i[2] ? ST_HIT3 : ST_ALARM;
      ST_HIT3:  next_o = ST_OPEN;
      ST_OPEN:  if (key_valid_i) next_o = ST_IDLE;
      ST_ALARM: if (clear_i)     next_o = ST_IDLE;
      default:  next_o = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/lock_out_decode.sv
module lock_out_decode
  import lock_pkg::*;
(
  input  lock_state_e        state_i,
  output logic               unlock_o,
  output logic               alarm_o,
  output logic [STATE_W-1:0] state_o
);
  assign unlock_o = (state_i == ST_OPEN);
  assign alarm_o  = (state_i == ST_ALARM);
  assign state_o  = state_i;
endmodule

// File: rtl/keypad_lock.sv
module keypad_lock
  import lock_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter logic [CODE_LEN*DIGIT_W-1:0] CODE = {4'd2, 4'd4, 4'd1}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIGIT_W-1:0] key_i,
  input  logic               key_valid_i,
  input  logic               clear_i,
  output logic               unlock_o,
  output logic               alarm_o,
  output logic [STATE_W-1:0] state_o
);
  logic [CODE_LEN-1:0] hit;
  lock_state_e state_q, state_d;

  lock_digit_match #(.DIGIT_W(DIGIT_W), .CODE_LEN(CODE_LEN), .CODE(CODE)) u_match (
    .key_i (key_i),
    .hit_o (hit)
  );

  lock_next_state #(.CODE_LEN(CODE_LEN)) u_next (
    .state_i     (state_q),
    .key_valid_i (key_valid_i),
    .clear_i     (clear_i),
    .hit_i       (hit),
    .next_o      (state_d)
  );

  // async reset for power-up only; all other changes are synchronous
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  lock_out_decode u_dec (
    .state_i  (state_q),
    .unlock_o (unlock_o),
    .alarm_o  (alarm_o),
    .state_o  (state_o)
  );

  assert_legal_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'b101);
  assert_outputs_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(unlock_o && alarm_o));
  assert_hold_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 3'b011 && !key_valid_i && !(state_o == 3'b101 && clear_i))
    |=> $stable(state_o));
  assert_hit3_to_open_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'b011) |=> unlock_o);
  assert_open_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlock_o && key_valid_i) |=> (state_o == 3'b000));
  assert_wrong_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'b000 && key_valid_i && key_i != CODE[DIGIT_W-1:0]) |=> alarm_o);
  assert_alarm_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && !clear_i) |=> alarm_o);
  assert_alarm_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && clear_i) |=> (state_o == 3'b000));
endmodule

// File: tb/keypad_lock_bench.sv
`timescale 1ns/1ps
module keypad_lock_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] key = '0;
  logic       kvalid = 1'b0;
  logic       clr = 1'b0;
  logic       unlock, alarm;
  logic [2:0] state;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keypad_lock u_keypad_lock (
    .clk_i(clk), .rst_ni(rst_n), .key_i(key), .key_valid_i(kvalid),
    .clear_i(clr), .unlock_o(unlock), .alarm_o(alarm), .state_o(state)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_state(string req, int st);
    check(req, state, st);
    check(req, unlock, st == 4);
    check(req, alarm, st == 5);
  endtask

  task automatic press(int k);
    key = k[3:0]; kvalid = 1'b1;
    @(posedge clk); #1;
    kvalid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(posedge clk); #1;
    clr = 1'b0;
  endtask

  task automatic t_reset();
    #1 expect_state("R1 in reset", 0);
    idle(2);
    rst_n = 1'b1;
    idle(1);
    expect_state("R1 after release", 0);
  endtask

  task automatic t_good_code();
    press(1); expect_state("R3 R2 first digit", 1);
    idle(3);  expect_state("R4 hold no key", 1);
    press(4); expect_state("R3 second digit", 2);
    press(2); expect_state("R3 third digit", 3);
    idle(1);  expect_state("R5 open", 4);
    idle(2);  expect_state("R4 open holds", 4);
    press(7); expect_state("R6 open to idle", 0);
  endtask

  task automatic t_wrong(int a, int b, int c, int n, string req);
    if (n >= 1) press(a);
    if (n >= 2) press(b);
    if (n >= 3) press(c);
    expect_state(req, 5);
    press(1); expect_state("R8 key ignored in alarm", 5);
    idle(2);  expect_state("R8 alarm holds", 5);
    do_clear(); expect_state("R8 clear to idle", 0);
  endtask

  task automatic t_clear_elsewhere();
    press(1);
    do_clear(); expect_state("R9 clear ignored", 1);
    press(4); press(2);
    key = 4'd9; kvalid = 1'b1; clr = 1'b1;
    @(posedge clk); #1;
    kvalid = 1'b0; clr = 1'b0;
    expect_state("R5 hit3 ignores inputs", 4);
    press(1); expect_state("R6 key 1 in open goes idle", 0);
  endtask

  task automatic t_clear_beats_key();
    press(3); expect_state("R7 wrong first", 5);
    key = 4'd1; kvalid = 1'b1; clr = 1'b1;
    @(posedge clk); #1;
    kvalid = 1'b0; clr = 1'b0;
    expect_state("R8 clear wins over key", 0);
  endtask

  task automatic t_async_reset();
    press(1); press(4);
    expect_state("R3 mid run", 2);
    #1 rst_n = 1'b0;
    #0.5 expect_state("R1 async reset", 0);
    @(negedge clk); rst_n = 1'b1;
    idle(1); expect_state("R1 idle after reset", 0);
  endtask

  initial begin
    t_reset();
    t_good_code();
    t_wrong(3, 0, 0, 1, "R7 wrong first digit");
    t_wrong(1, 1, 0, 2, "R7 wrong second digit");
    t_wrong(1, 4, 4, 3, "R7 wrong third digit");
    t_wrong(15, 0, 0, 1, "R7 key 15");
    t_wrong(1, 12, 0, 2, "R7 key 12");
    t_clear_elsewhere();
    t_clear_beats_key();
    do_clear();
    t_async_reset();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule